// File: doc/BRIEF.md
# Variable Product-Term AND-OR Array

This block is the programmable logic core of a small registered-logic device. It takes a vector of input and feedback signals and forms both the true and the inverted copy of each one; these copies are the array columns. Each product-term row is the AND of the columns its fuse bits select. Rows are grouped into ten sums of unequal size. Every output also has a dedicated enable row. Two further rows are shared by all outputs: an asynchronous-clear term and a synchronous-set term. The downstream output cells consume these signals.

The fuse map sits in registers. It is loaded through a word-wide configuration port, one array row per write, followed by one word of output-cell mode bits. Until that final word has been accepted, every array output is held inactive. The evaluation path from the inputs to the outputs is purely combinational.

Top module: `pt_array`

## Requirements
- R1: Input i drives column 2i with its true value and column 2i+1 with its inverted value. A row with fuse bit c set to 1 includes column c in its AND, and ignores column c when the bit is 0.
- R2: A row that selects both columns of the same input evaluates to 0 for every input pattern.
- R3: Row layout: row 0 is the shared clear term and the last row (131) is the shared set term. Between them, each output k in ascending order takes one enable row followed directly by its sum rows. With the default sizes, output 0 uses enable row 1 and sum rows 2 to 9, and output 9 uses enable row 122 and sum rows 123 to 130.
- R4: Output k ORs exactly its own sum rows. The ten budgets are 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 rows, so 120 sum rows in total.
- R5: A row with no fuse bit set counts as 1 when it is an enable row. The same empty row counts as 0 when it is a sum row or one of the two shared rows.
- R6: Each cycle with `cfg_we` high while loading is not complete stores `cfg_data` into the next row, starting at row 0. The write after row 131 is the mode word: its low 20 bits appear on `mc_cfg`, and `cfg_done` rises at the same clock edge.
- R7: While `cfg_done` is 0, `sum_o`, `oe_o`, `ar_o`, `sp_o` and `mc_cfg` are all 0.
- R8: Writes arriving after `cfg_done` is 1 change neither the fuse map nor `mc_cfg`.
- R9: An active-low `rst_n` clears `cfg_done` and `mc_cfg` and restarts loading at row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset of the loader |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_data | input | 44 | One row of fuse bits, or the mode word in bits 19:0 |
| x_i | input | 22 | Input and feedback signals |
| sum_o | output | 10 | Sum-of-products result per output |
| oe_o | output | 10 | Enable term per output |
| ar_o | output | 1 | Shared asynchronous-clear term |
| sp_o | output | 1 | Shared synchronous-set term |
| mc_cfg | output | 20 | Stored output-cell mode bits |
| cfg_done | output | 1 | Fuse map and mode word fully loaded |

## Verification
The in-module assertions check the loader on every cycle. They cover four things: when `cfg_done` rises, that it stays high and `mc_cfg` stays frozen afterwards, that a row write never completes loading, and that all outputs stay silent before completion. The logical function cannot be seen from a single cycle, so the bench shows it through its scenarios. These cover the column polarity, the row layout and budget boundaries, the empty-row rule, and rows that contradict themselves. The bench loads a patterned map and sweeps hundreds of input vectors against its own arithmetic model of the row layout.

// File: rtl/pt_array.sv
module pt_array #(
  parameter int NIN        = 22,
  parameter int NOUT       = 10,
  parameter int BASE_TERMS = 8,
  parameter int TERM_STEP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2*NIN-1:0]  cfg_data,
  input  logic [NIN-1:0]    x_i,
  output logic [NOUT-1:0]   sum_o,
  output logic [NOUT-1:0]   oe_o,
  output logic              ar_o,
  output logic              sp_o,
  output logic [2*NOUT-1:0] mc_cfg,
  output logic              cfg_done
);

  function automatic int terms_of(input int k);
    int h;
    h = (k < NOUT/2) ? k : NOUT - 1 - k;
    return BASE_TERMS + TERM_STEP * h;
  endfunction

  function automatic int oe_row(input int k);
    int r;
    r = 1;
    for (int j = 0; j < k; j++) r += 1 + terms_of(j);
    return r;
  endfunction

  localparam int NCOL  = 2 * NIN;
  localparam int NROWS = oe_row(NOUT) + 1;
  localparam int MCW   = 2 * NOUT;
  localparam int CW    = $clog2(NROWS + 1);

  logic [NCOL-1:0] fuse [NROWS];
  logic [CW-1:0]   ld_cnt;
  logic [MCW-1:0]  mc_q;
  logic [NCOL-1:0] col;
  logic [NROWS-1:0] hit, used;

  wire row_wr = cfg_we && !cfg_done && (ld_cnt < CW'(NROWS));

  always_ff @(posedge clk) begin
    if (row_wr) fuse[ld_cnt] <= cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_cnt   <= '0;
      mc_q     <= '0;
      cfg_done <= 1'b0;
    end else if (cfg_we && !cfg_done) begin
      if (ld_cnt == CW'(NROWS)) begin
        mc_q     <= cfg_data[MCW-1:0];
        cfg_done <= 1'b1;
      end else begin
        ld_cnt <= ld_cnt + 1'b1;
      end
    end
  end

  assign mc_cfg = mc_q;

  for (genvar i = 0; i < NIN; i++) begin : g_col
    assign col[2*i]   = x_i[i];
    assign col[2*i+1] = ~x_i[i];
  end

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    assign used[r] = |fuse[r];
    assign hit[r]  = &(col | ~fuse[r]);
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    localparam int OER = oe_row(k);
    localparam int TC  = terms_of(k);
    logic [TC-1:0] terms;
    for (genvar j = 0; j < TC; j++) begin : g_term
      assign terms[j] = hit[OER+1+j] & used[OER+1+j];
    end
    assign sum_o[k] = cfg_done & (|terms);
    assign oe_o[k]  = cfg_done & hit[OER];
  end

  assign ar_o = cfg_done & used[0] & hit[0];
  assign sp_o = cfg_done & used[NROWS-1] & hit[NROWS-1];

  // R6
  done_after_last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> $past(cfg_we) && ($past(ld_cnt) == CW'(NROWS)));

  // R6
  row_write_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_done && ld_cnt < CW'(NROWS)) |=> !cfg_done);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done && $stable(mc_cfg) && $stable(ld_cnt));

  // R7
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> (sum_o == '0) && (oe_o == '0) && !ar_o && !sp_o && (mc_cfg == '0));

endmodule

// File: tb/pt_array_tb.sv
module pt_array_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [43:0] cfg_data = '0;
  logic [21:0] x_i = '0;
  logic [9:0]  sum_o, oe_o;
  logic        ar_o, sp_o, cfg_done;
  logic [19:0] mc_cfg;

  pt_array u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .x_i(x_i), .sum_o(sum_o), .oe_o(oe_o), .ar_o(ar_o), .sp_o(sp_o),
    .mc_cfg(mc_cfg), .cfg_done(cfg_done));

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [43:0] bfuse [132];
  int tc [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
  int oer [10];
  localparam logic [19:0] MODE = 20'h5A3C9;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [43:0] make_row(input int r);
    logic [43:0] v;
    v = '0;
    if (r == 1 || (r >= 123 && r <= 130) || r % 7 == 3) return v;
    if (r >= 35 && r <= 48) begin
      v[2*(r%22)] = 1'b1;
      v[2*(r%22)+1] = 1'b1;
      return v;
    end
    v[(r*5)%44] = 1'b1;
    v[(r*11+3)%44] = 1'b1;
    return v;
  endfunction

  function automatic logic [1:0] row_eval(input int r, input logic [21:0] x);
    logic [43:0] c;
    for (int i = 0; i < 22; i++) begin
      c[2*i] = x[i];
      c[2*i+1] = ~x[i];
    end
    return {|bfuse[r], &(c | ~bfuse[r])};
  endfunction

  task automatic check_vector(input logic [21:0] x);
    logic [9:0] es, eo;
    logic [1:0] rv;
    logic ea, ep;
    x_i = x;
    #1;
    for (int k = 0; k < 10; k++) begin
      eo[k] = row_eval(oer[k], x)[0];
      es[k] = 1'b0;
      for (int j = 0; j < tc[k]; j++) begin
        rv = row_eval(oer[k] + 1 + j, x);
        es[k] = es[k] | (rv[1] & rv[0]);
      end
    end
    rv = row_eval(0, x);   ea = rv[1] & rv[0];
    rv = row_eval(131, x); ep = rv[1] & rv[0];
    chk(sum_o == es, "R4 sums", 64'(sum_o), 64'(es));
    chk(oe_o == eo, "R3 enables", 64'(oe_o), 64'(eo));
    chk(ar_o == ea && sp_o == ep, "R3 shared rows", {ar_o, sp_o}, {ea, ep});
    chk(sum_o[3] == 1'b0, "R2 contradictory rows", 64'(sum_o[3]), 0);
    chk(sum_o[9] == 1'b0 && oe_o[0] == 1'b1, "R5 empty rows", {sum_o[9], oe_o[0]}, 2'b01);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    int acc;
    acc = 1;
    for (int k = 0; k < 10; k++) begin
      oer[k] = acc;
      acc += 1 + tc[k];
    end
    for (int r = 0; r < 132; r++) bfuse[r] = make_row(r);

    x_i = '1;
    #12;
    chk(cfg_done == 0 && sum_o == 0 && oe_o == 0 && mc_cfg == 0, "R9 reset state",
        {cfg_done, sum_o, oe_o, mc_cfg}, 0);
    rst_n = 1'b1;

    for (int r = 0; r < 132; r++) begin
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_data = bfuse[r];
      if (r == 60)
        chk(!cfg_done && sum_o == 0 && oe_o == 0 && !ar_o && !sp_o, "R7 outputs idle while loading",
            {cfg_done, sum_o, oe_o, ar_o, sp_o}, 0);
    end
    @(negedge clk);
    chk(!cfg_done, "R6 not done before mode word", 64'(cfg_done), 0);
    cfg_data = {24'h0, MODE};
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_done == 1'b1, "R6 done after mode word", 64'(cfg_done), 1);
    chk(mc_cfg == MODE, "R6 mode bits", 64'(mc_cfg), 64'(MODE));

    x_i = 22'h1;
    #1;
    chk(ar_o == 1'b1, "R1 true/complement columns x0=1 x1=0", 64'(ar_o), 1);
    x_i = 22'h3;
    #1;
    chk(ar_o == 1'b0, "R1 complement column blocks x1=1", 64'(ar_o), 0);

    check_vector('0);
    check_vector('1);
    lf = 32'hACE1_2468;
    for (int n = 0; n < 400; n++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      check_vector(lf[21:0]);
    end

    @(negedge clk);
    cfg_we = 1'b1;
    cfg_data = '1;
    @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(mc_cfg == MODE && cfg_done, "R8 late write ignored (mode)", 64'(mc_cfg), 64'(MODE));
    check_vector(22'h2AAAAA);
    check_vector(22'h155555);

    rst_n = 1'b0;
    #1;
    chk(cfg_done == 0 && mc_cfg == 0 && sum_o == 0 && oe_o == 0, "R9 reset clears loader",
        {cfg_done, mc_cfg, sum_o, oe_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cfg_done && !ar_o && !sp_o, "R7 idle after reset", {cfg_done, ar_o, sp_o}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule